// File: doc/BRIEF.md
# Microsequencer with Dispatch Table and Return Stack

This block is the next-address engine of a writable-microcode processor. Each clock it sees the transfer fields of the microinstruction now executing. It then picks the address of the word to fetch next: the following address, the target of a jump, an entry from a 1024-entry dispatch table, or an address popped from a 32-entry return stack. Fetch runs one instruction ahead of execution, so the word after a taken transfer executes as a delay slot. That slot can be suppressed, and the lost cycle is flagged on `squash`.

A transfer carries three control bits: inhibit (`xfer_n`), push (`xfer_p`) and pop (`xfer_r`). Jump instructions supply these bits directly. For a dispatch, the same bits come from the table entry. That entry is addressed by ORing a masked field of the low bits of the rotated M word into an offset. A write transfer does not jump. Instead it asks the external microcode store for a write strobe at the target address and then returns by itself. The table is filled through a plain load port.

There is no stream traffic at this block's edges. Every control pin is sampled on every rising clock edge. There is no valid/ready pairing and no back-pressure: the sequencer advances one step per clock.

Top module: `microseq`

## Requirements
- R1: While `rst` is high and after its release, `fetch_pc` is 0 and `squash` and `wr_strobe` are low.
- R2: With `op_kind` = 0 (sequential) and `pop_bit` low, `fetch_pc` rises by one per clock and wraps from 4095 to 0.
- R3: With `op_kind` = 1 (jump), the condition is chosen by `cond_sel`: 0 selects `m_low[0]`, 1 selects `alu_carry`, 2 selects `alu_zero`, and 3 means always. When the condition holds, `fetch_pc` takes the new address on the next clock. When it fails, `fetch_pc` increments and there is no stack change and no squash.
- R4: A taken transfer with the inhibit bit set drives `squash` high for exactly the following cycle. During that cycle every transfer field, including `pop_bit`, is ignored and `fetch_pc` increments.
- R5: The push/pop pair {P,R} = 10 is a call. It pushes `fetch_pc`+1, which is the address two past the calling instruction. {P,R} = 01 is a return. It loads the popped address and ignores the new-address field.
- R6: The return stack is last-in first-out with 32 entries. Its pointer wraps modulo 32 without any overflow detection, so a pop from an empty stack returns the entry at slot 31.
- R7: With `op_kind` = 2 (dispatch), the table address is `disp_offset` OR the low `disp_width` bits of `m_low`. A width above 8 acts as 8.
- R8: A dispatch is always taken. It uses the entry's bits: new address in 11..0, inhibit in bit 12, push in bit 13, pop in bit 14.
- R9: {P,R} = 11 is a write transfer. It pushes like a call and moves `fetch_pc` to the target, and `wr_strobe` is high for the next cycle only, while `fetch_pc` holds the target. In that strobe cycle the inputs are ignored and the stack is popped. In the cycle after, `squash` is high and `fetch_pc` equals the write instruction's address plus two.
- R10: `pop_bit` high on an unsquashed instruction pops the stack into `fetch_pc` with no squash. It overrides that instruction's own transfer type and inhibit bit.
- R11: `tbl_we` high writes `tbl_data` into table slot `tbl_addr` on the clock edge. Dispatches on later cycles see the new entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_kind | input | 2 | 0 sequential, 1 jump, 2 dispatch, 3 treated as sequential |
| pop_bit | input | 1 | Extra return-type pop on this instruction |
| xfer_n | input | 1 | Jump inhibit bit (squash the delay slot) |
| xfer_p | input | 1 | Jump push bit |
| xfer_r | input | 1 | Jump pop bit |
| jump_pc | input | 12 | Jump target address |
| cond_sel | input | 2 | Jump condition select |
| alu_carry | input | 1 | ALU carry result |
| alu_zero | input | 1 | ALU zero result |
| m_low | input | 8 | Low bits of the rotated M word |
| disp_width | input | 4 | Number of dispatch field bits |
| disp_offset | input | 10 | Dispatch table base offset |
| tbl_we | input | 1 | Dispatch table write enable |
| tbl_addr | input | 10 | Dispatch table write slot |
| tbl_data | input | 15 | Dispatch table write word |
| fetch_pc | output | 12 | Address of the word fetched this cycle; write address when `wr_strobe` is high |
| squash | output | 1 | Instruction executing this cycle is to be discarded |
| wr_strobe | output | 1 | Write the microcode store at `fetch_pc` this cycle |

## Verification
Jumps are tried with each condition source both held and failing. A failing condition must leave the count unbroken, and a held one must redirect it. Calls, returns and the pop bit are nested so that only a true last-in first-out order gives the right return addresses. Thirty-two back-to-back calls and thirty-three returns show that the pointer wraps. Dispatches use M words with set bits outside the field and a width larger than eight, which separates masking from plain OR. Squashed and strobe cycles are driven with live jump fields, so any leak of those fields into the sequence shows up in `fetch_pc`.

// File: rtl/microseq_pkg.sv
package microseq_pkg;

  localparam int PC_W_DEF    = 12;
  localparam int STK_DEF     = 32;
  localparam int TBL_AW_DEF  = 10;
  localparam int FLD_MAX_DEF = 8;

  typedef enum logic [1:0] {
    OP_SEQ  = 2'd0,
    OP_JUMP = 2'd1,
    OP_DISP = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    CS_MBIT0  = 2'd0,
    CS_CARRY  = 2'd1,
    CS_ZERO   = 2'd2,
    CS_ALWAYS = 2'd3
  } cond_e;

  // control bits {push, pop}
  typedef enum logic [1:0] {
    TT_JUMP  = 2'b00,
    TT_RET   = 2'b01,
    TT_CALL  = 2'b10,
    TT_WRITE = 2'b11
  } ttype_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic load;
    logic from_stack;
    logic squash;
    logic write;
  } seq_ctl_t;

endpackage

// File: rtl/microseq_rstack.sv
module microseq_rstack #(
  parameter int DW    = 12,
  parameter int DEPTH = 32,
  localparam int SPW  = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] top
);

  logic [SPW-1:0] sp;
  logic [DW-1:0]  slots [DEPTH];

  // pointer names the next free slot; top sits just below it
  assign top = slots[sp - 1'b1];

  always_ff @(posedge clk) begin
    if (push && !pop) slots[sp] <= wdata;
  end

  // pop wins over a simultaneous push
  always_ff @(posedge clk) begin
    if (rst)       sp <= '0;
    else if (pop)  sp <= sp - 1'b1;
    else if (push) sp <= sp + 1'b1;
  end

  a_r6_push_advances: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> sp == SPW'($past(sp) + 1'b1));

  a_r6_pop_retreats: assert property (@(posedge clk) disable iff (rst)
    pop |=> sp == SPW'($past(sp) - 1'b1));

  a_r5_push_becomes_top: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> top == $past(wdata));

endmodule

// File: rtl/microseq_dtable.sv
module microseq_dtable #(
  parameter int PC_W    = 12,
  parameter int AW      = 10,
  parameter int FLD_MAX = 8,
  localparam int WW     = $clog2(FLD_MAX + 1),
  localparam int EW     = PC_W + 3,
  localparam int DEPTH  = 1 << AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tbl_we,
  input  logic [AW-1:0]      tbl_addr,
  input  logic [EW-1:0]      tbl_data,
  input  logic [FLD_MAX-1:0] m_low,
  input  logic [WW-1:0]      width,
  input  logic [AW-1:0]      offset,
  output logic               ent_n,
  output logic               ent_p,
  output logic               ent_r,
  output logic [PC_W-1:0]    ent_pc
);

  logic [EW-1:0]      entries [DEPTH];
  logic [WW-1:0]      eff_w;
  logic [FLD_MAX-1:0] mask;
  logic [FLD_MAX-1:0] field;
  logic [AW-1:0]      raddr;
  logic [EW-1:0]      rword;

  assign eff_w = (width > WW'(FLD_MAX)) ? WW'(FLD_MAX) : width;

  for (genvar i = 0; i < FLD_MAX; i++) begin : g_mask
    assign mask[i] = (eff_w > WW'(i));
  end

  assign field  = m_low & mask;
  assign raddr  = offset | AW'(field);
  assign rword  = entries[raddr];
  assign ent_pc = rword[PC_W-1:0];
  assign ent_n  = rword[PC_W];
  assign ent_p  = rword[PC_W+1];
  assign ent_r  = rword[PC_W+2];

  always_ff @(posedge clk) begin
    if (tbl_we) entries[tbl_addr] <= tbl_data;
  end

  a_r11_load_lands: assert property (@(posedge clk) disable iff (rst)
    tbl_we |=> entries[$past(tbl_addr)] == $past(tbl_data));

endmodule

// File: rtl/microseq_xfer.sv
module microseq_xfer
  import microseq_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic [1:0]      op_kind,
  input  logic            pop_bit,
  input  logic [1:0]      cond_sel,
  input  logic            mbit0,
  input  logic            carry,
  input  logic            zero,
  input  logic            jn,
  input  logic            jp,
  input  logic            jr,
  input  logic [PC_W-1:0] jpc,
  input  logic            dn,
  input  logic            dp,
  input  logic            dr,
  input  logic [PC_W-1:0] dpc,
  input  logic            squash_in,
  input  logic            strobe_in,
  output seq_ctl_t        ctl,
  output logic [PC_W-1:0] target
);

  logic   cond_ok;
  logic   is_disp;
  logic   is_jump;
  logic   take;
  logic   sel_n;
  ttype_e ttype;

  always_comb begin
    case (cond_e'(cond_sel))
      CS_MBIT0: cond_ok = mbit0;
      CS_CARRY: cond_ok = carry;
      CS_ZERO:  cond_ok = zero;
      default:  cond_ok = 1'b1;
    endcase
  end

  assign is_disp = (op_e'(op_kind) == OP_DISP);
  assign is_jump = (op_e'(op_kind) == OP_JUMP);
  assign take    = is_disp || (is_jump && cond_ok);
  assign sel_n   = is_disp ? dn : jn;
  assign ttype   = is_disp ? ttype_e'({dp, dr}) : ttype_e'({jp, jr});
  assign target  = is_disp ? dpc : jpc;

  always_comb begin
    ctl = '0;
    if (strobe_in) begin
      // write cycle: forced return, next slot is a bubble
      ctl.pop        = 1'b1;
      ctl.load       = 1'b1;
      ctl.from_stack = 1'b1;
      ctl.squash     = 1'b1;
    end else if (!squash_in) begin
      if (pop_bit) begin
        ctl.pop        = 1'b1;
        ctl.load       = 1'b1;
        ctl.from_stack = 1'b1;
      end else if (take) begin
        ctl.load   = 1'b1;
        ctl.squash = sel_n;
        case (ttype)
          TT_CALL: ctl.push = 1'b1;
          TT_RET: begin
            ctl.pop        = 1'b1;
            ctl.from_stack = 1'b1;
          end
          TT_WRITE: begin
            ctl.push  = 1'b1;
            ctl.write = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/microseq.sv
module microseq
  import microseq_pkg::*;
#(
  parameter int PC_W    = PC_W_DEF,
  parameter int STK     = STK_DEF,
  parameter int TBL_AW  = TBL_AW_DEF,
  parameter int FLD_MAX = FLD_MAX_DEF,
  localparam int WW     = $clog2(FLD_MAX + 1),
  localparam int EW     = PC_W + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         op_kind,
  input  logic               pop_bit,
  input  logic               xfer_n,
  input  logic               xfer_p,
  input  logic               xfer_r,
  input  logic [PC_W-1:0]    jump_pc,
  input  logic [1:0]         cond_sel,
  input  logic               alu_carry,
  input  logic               alu_zero,
  input  logic [FLD_MAX-1:0] m_low,
  input  logic [WW-1:0]      disp_width,
  input  logic [TBL_AW-1:0]  disp_offset,
  input  logic               tbl_we,
  input  logic [TBL_AW-1:0]  tbl_addr,
  input  logic [EW-1:0]      tbl_data,
  output logic [PC_W-1:0]    fetch_pc,
  output logic               squash,
  output logic               wr_strobe
);

  logic [PC_W-1:0] pc_q;
  logic            squash_q;
  logic            wr_q;
  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] stk_top;
  logic [PC_W-1:0] target;
  logic            ent_n, ent_p, ent_r;
  logic [PC_W-1:0] ent_pc;
  seq_ctl_t        ctl;

  assign pc_inc = pc_q + 1'b1;

  microseq_dtable #(
    .PC_W(PC_W), .AW(TBL_AW), .FLD_MAX(FLD_MAX)
  ) u_dtable (
    .clk(clk), .rst(rst),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .m_low(m_low), .width(disp_width), .offset(disp_offset),
    .ent_n(ent_n), .ent_p(ent_p), .ent_r(ent_r), .ent_pc(ent_pc)
  );

  microseq_xfer #(.PC_W(PC_W)) u_xfer (
    .op_kind(op_kind), .pop_bit(pop_bit), .cond_sel(cond_sel),
    .mbit0(m_low[0]), .carry(alu_carry), .zero(alu_zero),
    .jn(xfer_n), .jp(xfer_p), .jr(xfer_r), .jpc(jump_pc),
    .dn(ent_n), .dp(ent_p), .dr(ent_r), .dpc(ent_pc),
    .squash_in(squash_q), .strobe_in(wr_q),
    .ctl(ctl), .target(target)
  );

  // return address is two past the executing instruction
  microseq_rstack #(.DW(PC_W), .DEPTH(STK)) u_stack (
    .clk(clk), .rst(rst),
    .push(ctl.push), .pop(ctl.pop),
    .wdata(pc_inc), .top(stk_top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      squash_q <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      if (ctl.load) pc_q <= ctl.from_stack ? stk_top : target;
      else          pc_q <= pc_inc;
      squash_q <= ctl.squash;
      wr_q     <= ctl.write;
    end
  end

  assign fetch_pc  = pc_q;
  assign squash    = squash_q;
  assign wr_strobe = wr_q;

  a_r2_sequential_step: assert property (@(posedge clk) disable iff (rst)
    (op_kind == 2'd0 && !pop_bit && !wr_strobe)
      |=> fetch_pc == PC_W'($past(fetch_pc) + 1'b1));

  a_r4_squashed_slot_inert: assert property (@(posedge clk) disable iff (rst)
    (squash && !wr_strobe) |=> fetch_pc == PC_W'($past(fetch_pc) + 1'b1));

  a_r9_strobe_then_bubble: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |=> (squash && !wr_strobe));

  a_r9_strobe_single: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_strobe) |=> $fell(wr_strobe));

endmodule

// File: tb/microseq_test.sv
module microseq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  op_kind = 2'd0;
  logic        pop_bit = 1'b0;
  logic        xfer_n = 1'b0, xfer_p = 1'b0, xfer_r = 1'b0;
  logic [11:0] jump_pc = 12'd0;
  logic [1:0]  cond_sel = 2'd3;
  logic        alu_carry = 1'b0, alu_zero = 1'b0;
  logic [7:0]  m_low = 8'd0;
  logic [3:0]  disp_width = 4'd0;
  logic [9:0]  disp_offset = 10'd0;
  logic        tbl_we = 1'b0;
  logic [9:0]  tbl_addr = 10'd0;
  logic [14:0] tbl_data = 15'd0;
  logic [11:0] fetch_pc;
  logic        squash, wr_strobe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    string       tag;
    logic [11:0] pc;
    logic        sq;
    logic        st;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  microseq uut (
    .clk(clk), .rst(rst), .op_kind(op_kind), .pop_bit(pop_bit),
    .xfer_n(xfer_n), .xfer_p(xfer_p), .xfer_r(xfer_r), .jump_pc(jump_pc),
    .cond_sel(cond_sel), .alu_carry(alu_carry), .alu_zero(alu_zero),
    .m_low(m_low), .disp_width(disp_width), .disp_offset(disp_offset),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .fetch_pc(fetch_pc), .squash(squash), .wr_strobe(wr_strobe)
  );

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // driver: apply one cycle of inputs, queue the outputs expected after the edge
  task automatic drive(input string tag, input logic [1:0] op, input logic pb,
                       input logic n, input logic p, input logic r,
                       input logic [11:0] tgt, input logic [1:0] cs,
                       input logic [7:0] mw, input logic cy, input logic zr,
                       input logic [3:0] w, input logic [9:0] off,
                       input logic we, input logic [9:0] wa, input logic [14:0] wd,
                       input logic [11:0] epc, input logic esq, input logic est);
    exp_t e;
    @(negedge clk);
    op_kind = op; pop_bit = pb; xfer_n = n; xfer_p = p; xfer_r = r;
    jump_pc = tgt; cond_sel = cs; m_low = mw; alu_carry = cy; alu_zero = zr;
    disp_width = w; disp_offset = off; tbl_we = we; tbl_addr = wa; tbl_data = wd;
    e.tag = tag; e.pc = epc; e.sq = esq; e.st = est;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag, input logic [11:0] epc,
                      input logic esq, input logic est);
    drive(tag, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h0, 2'd3, 8'h0, 1'b0, 1'b0,
          4'd0, 10'h0, 1'b0, 10'h0, 15'h0, epc, esq, est);
  endtask

  task automatic jump(input string tag, input logic [1:0] cs,
                      input logic n, input logic p, input logic r,
                      input logic [11:0] tgt, input logic [7:0] mw,
                      input logic cy, input logic zr,
                      input logic [11:0] epc, input logic esq, input logic est);
    drive(tag, 2'd1, 1'b0, n, p, r, tgt, cs, mw, cy, zr,
          4'd0, 10'h0, 1'b0, 10'h0, 15'h0, epc, esq, est);
  endtask

  task automatic disp(input string tag, input logic [7:0] mw, input logic [3:0] w,
                      input logic [9:0] off, input logic [11:0] epc,
                      input logic esq, input logic est);
    drive(tag, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 12'hFFF, 2'd3, mw, 1'b0, 1'b0,
          w, off, 1'b0, 10'h0, 15'h0, epc, esq, est);
  endtask

  task automatic load(input string tag, input logic [9:0] wa, input logic [14:0] wd,
                      input logic [11:0] epc);
    drive(tag, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h0, 2'd3, 8'h0, 1'b0, 1'b0,
          4'd0, 10'h0, 1'b1, wa, wd, epc, 1'b0, 1'b0);
  endtask

  // monitor: compare after each rising edge, away from the edge itself
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (fetch_pc !== e.pc || squash !== e.sq || wr_strobe !== e.st) begin
          errors++;
          $display("FAIL %s: actual pc=%h sq=%b st=%b expected pc=%h sq=%b st=%b",
                   e.tag, fetch_pc, squash, wr_strobe, e.pc, e.sq, e.st);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout, expected completion");
    finish_run();
  end

  initial begin
    logic [11:0] rets [32];
    logic [11:0] cur;

    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (fetch_pc !== 12'h000 || squash !== 1'b0 || wr_strobe !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual pc=%h sq=%b st=%b expected pc=000 sq=0 st=0",
               fetch_pc, squash, wr_strobe);
    end
    rst = 1'b0;   // following edge moves pc 0 -> 1

    idle("R2 step", 12'h002, 1'b0, 1'b0);
    idle("R2 step", 12'h003, 1'b0, 1'b0);
    jump("R3 always", 2'd3, 1'b0, 1'b0, 1'b0, 12'h100, 8'h00, 1'b0, 1'b0, 12'h100, 1'b0, 1'b0);
    idle("R3 delay slot", 12'h101, 1'b0, 1'b0);
    jump("R3 mbit0 false", 2'd0, 1'b0, 1'b0, 1'b0, 12'h200, 8'h02, 1'b1, 1'b1, 12'h102, 1'b0, 1'b0);
    jump("R4 carry taken N", 2'd1, 1'b1, 1'b0, 1'b0, 12'h200, 8'h00, 1'b1, 1'b0, 12'h200, 1'b1, 1'b0);
    jump("R4 squashed slot ignored", 2'd3, 1'b0, 1'b0, 1'b0, 12'h300, 8'h00, 1'b0, 1'b0, 12'h201, 1'b0, 1'b0);
    jump("R3 zero false", 2'd2, 1'b0, 1'b0, 1'b0, 12'h300, 8'h01, 1'b1, 1'b0, 12'h202, 1'b0, 1'b0);
    jump("R5 call on zero", 2'd2, 1'b0, 1'b1, 1'b0, 12'h050, 8'h00, 1'b0, 1'b1, 12'h050, 1'b0, 1'b0);
    idle("R5 step", 12'h051, 1'b0, 1'b0);
    jump("R5 nested call", 2'd3, 1'b0, 1'b1, 1'b0, 12'h060, 8'h00, 1'b0, 1'b0, 12'h060, 1'b0, 1'b0);
    idle("R5 step", 12'h061, 1'b0, 1'b0);
    jump("R5 return ignores target", 2'd3, 1'b0, 1'b0, 1'b1, 12'hFFF, 8'h00, 1'b0, 1'b0, 12'h052, 1'b0, 1'b0);
    idle("R5 step", 12'h053, 1'b0, 1'b0);
    jump("R6 lifo outer return", 2'd3, 1'b0, 1'b0, 1'b1, 12'h777, 8'h00, 1'b0, 1'b0, 12'h203, 1'b0, 1'b0);
    idle("R6 step", 12'h204, 1'b0, 1'b0);

    load("R11 load A", 10'h2A5, 15'h0345, 12'h205);
    load("R11 load B", 10'h0F3, 15'h3700, 12'h206);
    disp("R7 width 4 offset OR", 8'hF5, 4'd4, 10'h2A0, 12'h345, 1'b0, 1'b0);
    idle("R7 step", 12'h346, 1'b0, 1'b0);
    disp("R8 entry call with N", 8'hF3, 4'd8, 10'h000, 12'h700, 1'b1, 1'b0);
    idle("R8 squashed slot", 12'h701, 1'b0, 1'b0);
    drive("R10 pop bit alone", 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 12'h0, 2'd3, 8'h0, 1'b0, 1'b0,
          4'd0, 10'h0, 1'b0, 10'h0, 15'h0, 12'h347, 1'b0, 1'b0);
    idle("R10 step", 12'h348, 1'b0, 1'b0);

    jump("R9 write transfer", 2'd3, 1'b0, 1'b1, 1'b1, 12'h0AB, 8'h00, 1'b0, 1'b0, 12'h0AB, 1'b0, 1'b1);
    jump("R9 strobe cycle ignores inputs", 2'd3, 1'b0, 1'b0, 1'b0, 12'h111, 8'h00, 1'b0, 1'b0, 12'h349, 1'b1, 1'b0);
    jump("R9 bubble ignores inputs", 2'd3, 1'b0, 1'b0, 1'b0, 12'h222, 8'h00, 1'b0, 1'b0, 12'h34A, 1'b0, 1'b0);
    idle("R9 resume", 12'h34B, 1'b0, 1'b0);

    jump("R10 setup call", 2'd3, 1'b0, 1'b1, 1'b0, 12'h400, 8'h00, 1'b0, 1'b0, 12'h400, 1'b0, 1'b0);
    idle("R10 step", 12'h401, 1'b0, 1'b0);
    drive("R10 pop bit overrides jump N", 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 12'h500, 2'd3, 8'h0,
          1'b0, 1'b0, 4'd0, 10'h0, 1'b0, 10'h0, 15'h0, 12'h34C, 1'b0, 1'b0);
    idle("R10 step", 12'h34D, 1'b0, 1'b0);

    jump("R2 jump near top", 2'd3, 1'b0, 1'b0, 1'b0, 12'hFFE, 8'h00, 1'b0, 1'b0, 12'hFFE, 1'b0, 1'b0);
    idle("R2 step", 12'hFFF, 1'b0, 1'b0);
    idle("R2 wrap", 12'h000, 1'b0, 1'b0);
    idle("R2 step", 12'h001, 1'b0, 1'b0);

    cur = 12'h001;
    for (int k = 0; k < 32; k++) begin
      rets[k] = cur + 12'd1;
      cur = 12'h800 + 12'(2 * k);
      jump("R6 fill call", 2'd3, 1'b0, 1'b1, 1'b0, cur, 8'h00, 1'b0, 1'b0, cur, 1'b0, 1'b0);
    end
    for (int j = 0; j < 32; j++) begin
      jump("R6 drain return", 2'd3, 1'b0, 1'b0, 1'b1, 12'h000, 8'h00, 1'b0, 1'b0,
           rets[31 - j], 1'b0, 1'b0);
    end
    jump("R6 wrapped pop", 2'd3, 1'b0, 1'b0, 1'b1, 12'h000, 8'h00, 1'b0, 1'b0, rets[31], 1'b0, 1'b0);
    cur = rets[31] + 12'd1;
    idle("R6 step", cur, 1'b0, 1'b0);
    cur = cur + 12'd1;
    load("R11 load C", 10'h305, 15'h00C0, cur);
    disp("R7 width clamp", 8'h05, 4'd15, 10'h300, 12'h0C0, 1'b0, 1'b0);
    idle("R7 step", 12'h0C1, 1'b0, 1'b0);

    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule